// File: doc/BRIEF.md
# Closed-Loop Latency Priority Regulator

This block sits beside one master port and watches its read traffic. Each accepted read request gets the current value of a free-running cycle counter as a timestamp. The timestamp goes into a small in-order queue. When the final beat of the oldest read response is accepted, the block takes that timestamp out of the queue. The difference from the current count is the transaction's latency in cycles.

Each measured latency is compared with a programmed target. If the master waited longer than the target, the priority attached to its new requests goes up by a programmed step. If it waited less, the priority goes down by the same step. If the latency equals the target, the priority is left unchanged. The priority starts at zero and saturates at both ends. The loop therefore settles at the lowest priority that still meets the target, and the master yields bandwidth when the system is lightly loaded.

The block only observes the handshakes. It never stalls either channel. Responses are assumed to return in request order for a single ID.

Top module: `lat_prio_regulator`

## Requirements
- R1: After reset, and in every cycle after one in which `enable` is low, `prio_o` is 0. While `enable` is low, no handshake is recorded and any queued timestamps are discarded.
- R2: A request is recorded only at a clock edge where `req_valid` and `req_ready` are both 1. A response completes only at an edge where `rsp_valid`, `rsp_ready` and `rsp_last` are all 1. Beats without `rsp_last` and transfers without the handshake have no effect on `prio_o`.
- R3: The measured latency is the number of clock edges from the request's handshake edge to its completing edge. A response at the edge right after the request measures 1.
- R4: If the latency is greater than `cfg_target`, `prio_o` rises by `cfg_step`, saturating at 15 and never wrapping.
- R5: If the latency is less than `cfg_target`, `prio_o` falls by `cfg_step`, saturating at 0 and never wrapping.
- R6: If the latency equals `cfg_target`, `prio_o` is unchanged.
- R7: Up to 8 requests may be outstanding. Completions are matched to requests oldest first. A request handshake and a completion at the same edge are both taken.
- R8: A completion while nothing is outstanding is ignored. This includes a completion at the same edge as the first request.
- R9: `prio_o` is registered. It changes at most once per completion, at the completing edge, and holds at all other edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Regulation enable; low clears the queue and the priority |
| req_valid | input | 1 | Observed read-request valid |
| req_ready | input | 1 | Observed read-request ready |
| rsp_valid | input | 1 | Observed read-response valid |
| rsp_ready | input | 1 | Observed read-response ready |
| rsp_last | input | 1 | Observed read-response final-beat flag |
| cfg_target | input | 16 | Target latency in cycles |
| cfg_step | input | 4 | Priority change per measurement |
| prio_o | output | 4 | Priority for new requests |

## Verification
The timestamp queue can be written by a new request and read by a completion at the same clock edge. A related case is a completion arriving at the same edge as the first request, while the queue is still empty. The bench provokes both by driving overlapping request and response streams, with back-to-back requests whose responses fall on later request edges, and by a lone same-edge request and response. A reference queue in the bench, updated pop-first then push, predicts every latency and the resulting priority, and each completion's priority is compared the cycle after.

// File: rtl/lpr_pkg.sv
package lpr_pkg;

   typedef enum logic [1:0] {
      LPR_HOLD  = 2'b00,
      LPR_RAISE = 2'b01,
      LPR_LOWER = 2'b10
   } lpr_dir_e;

endpackage

// File: rtl/lpr_stamp_fifo.sv
module lpr_stamp_fifo #(
   parameter int DEPTH = 8,
   parameter int W     = 16,
   localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  dout,
   output logic [CW-1:0] occ,
   output logic          full
);

   logic [CW-1:0] occ_q;
   logic          do_push;

   assign full    = (occ_q == CW'(DEPTH));
   assign do_push = push && (!full || pop);
   assign occ     = occ_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         occ_q <= '0;
      end else if (clr) begin
         occ_q <= '0;
      end else begin
         case ({do_push, pop})
            2'b10:   occ_q <= occ_q + 1'b1;
            2'b01:   occ_q <= occ_q - 1'b1;
            default: occ_q <= occ_q;
         endcase
      end
   end

   generate
      if (DEPTH == 1) begin : g_single
         logic [W-1:0] slot_q;
         always_ff @(posedge clk) begin
            if (do_push) slot_q <= din;
         end
         assign dout = slot_q;
      end else begin : g_ring
         logic [W-1:0]  mem [DEPTH];
         logic [AW-1:0] wr_q, rd_q;

         function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
            return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
         endfunction

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               wr_q <= '0;
               rd_q <= '0;
            end else if (clr) begin
               wr_q <= '0;
               rd_q <= '0;
            end else begin
               if (do_push) wr_q <= nxt(wr_q);
               if (pop)     rd_q <= nxt(rd_q);
            end
         end

         always_ff @(posedge clk) begin
            if (do_push) mem[wr_q] <= din;
         end

         assign dout = mem[rd_q];
      end
   endgenerate

endmodule

// File: rtl/lpr_lat_meter.sv
module lpr_lat_meter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] stamp_i,
   output logic [W-1:0] now_o,
   output logic [W-1:0] lat_o
);

   logic [W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) cnt_q <= '0;
      else        cnt_q <= cnt_q + 1'b1;
   end

   assign now_o = cnt_q;
   // modulo difference stays correct while latency < 2**W
   assign lat_o = cnt_q - stamp_i;

endmodule

// File: rtl/lpr_prio_ctrl.sv
module lpr_prio_ctrl
   import lpr_pkg::*;
#(
   parameter int PW = 4,
   parameter int W  = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          fire,
   input  logic [W-1:0]  lat,
   input  logic [W-1:0]  target,
   input  logic [PW-1:0] step,
   output logic [PW-1:0] prio_o
);

   localparam logic [PW-1:0] PMAX = '1;

   logic [PW-1:0] prio_q, up_v, dn_v;
   logic [PW:0]   sum;
   lpr_dir_e      dir;

   always_comb begin
      if (lat > target)      dir = LPR_RAISE;
      else if (lat < target) dir = LPR_LOWER;
      else                   dir = LPR_HOLD;
   end

   assign sum  = {1'b0, prio_q} + {1'b0, step};
   assign up_v = sum[PW] ? PMAX : sum[PW-1:0];
   assign dn_v = (step > prio_q) ? '0 : prio_q - step;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prio_q <= '0;
      end else if (clr) begin
         prio_q <= '0;
      end else if (fire) begin
         case (dir)
            LPR_RAISE: prio_q <= up_v;
            LPR_LOWER: prio_q <= dn_v;
            default:   prio_q <= prio_q;
         endcase
      end
   end

   assign prio_o = prio_q;

endmodule

// File: rtl/lat_prio_regulator.sv
module lat_prio_regulator #(
   parameter int PRIO_W = 4,
   parameter int LAT_W  = 16,
   parameter int DEPTH  = 8,
   localparam int CW    = $clog2(DEPTH + 1)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              enable,
   input  logic              req_valid,
   input  logic              req_ready,
   input  logic              rsp_valid,
   input  logic              rsp_ready,
   input  logic              rsp_last,
   input  logic [LAT_W-1:0]  cfg_target,
   input  logic [PRIO_W-1:0] cfg_step,
   output logic [PRIO_W-1:0] prio_o
);

   generate
      if (PRIO_W < 1 || PRIO_W > 8) begin : g_bad_pw
         $error("PRIO_W must lie in 1..8");
      end
      if (LAT_W < 2) begin : g_bad_lw
         $error("LAT_W must be at least 2");
      end
      if (DEPTH < 1 || DEPTH > 64) begin : g_bad_depth
         $error("DEPTH must lie in 1..64");
      end
   endgenerate

   logic              push, cmpl, fire, full, clr;
   logic [CW-1:0]     occ;
   logic [LAT_W-1:0]  now, stamp, lat;

   assign clr  = !enable;
   assign push = enable && req_valid && req_ready;
   assign cmpl = enable && rsp_valid && rsp_ready && rsp_last;
   assign fire = cmpl && (occ != '0);

   lpr_lat_meter #(.W(LAT_W)) u_meter (
      .clk     (clk),
      .rst_n   (rst_n),
      .stamp_i (stamp),
      .now_o   (now),
      .lat_o   (lat)
   );

   lpr_stamp_fifo #(.DEPTH(DEPTH), .W(LAT_W)) u_fifo (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (clr),
      .push  (push),
      .pop   (fire),
      .din   (now),
      .dout  (stamp),
      .occ   (occ),
      .full  (full)
   );

   lpr_prio_ctrl #(.PW(PRIO_W), .W(LAT_W)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (clr),
      .fire   (fire),
      .lat    (lat),
      .target (cfg_target),
      .step   (cfg_step),
      .prio_o (prio_o)
   );

endmodule

// File: rtl/lpr_checker.sv
module lpr_checker #(
   parameter int PRIO_W = 4,
   parameter int LAT_W  = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              enable,
   input logic              cmpl,
   input logic              fire,
   input logic              push,
   input logic              full,
   input logic [LAT_W-1:0]  lat,
   input logic [LAT_W-1:0]  target,
   input logic [PRIO_W-1:0] prio
);

   localparam logic [PRIO_W-1:0] PMAX = '1;

   assert_idle_floor_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !enable |=> (prio == '0));

   assert_raise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fire && lat > target) |=>
         ((prio > $past(prio)) || ($past(prio) == PMAX)));

   assert_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fire && lat < target) |=>
         ((prio < $past(prio)) || ($past(prio) == '0)));

   assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && fire && lat == target) |=> $stable(prio));

   assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !(push && full && !fire));

   assert_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (enable && !cmpl) |=> $stable(prio));

endmodule

bind lat_prio_regulator lpr_checker #(.PRIO_W(PRIO_W), .LAT_W(LAT_W)) u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .enable (enable),
   .cmpl   (cmpl),
   .fire   (fire),
   .push   (push),
   .full   (full),
   .lat    (lat),
   .target (cfg_target),
   .prio   (prio_o)
);

// File: tb/lat_prio_regulator_tb_top.sv
module lat_prio_regulator_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        enable = 1'b0;
   logic        req_valid = 1'b0, req_ready = 1'b0;
   logic        rsp_valid = 1'b0, rsp_ready = 1'b0, rsp_last = 1'b0;
   logic [15:0] cfg_target = 16'd4;
   logic [3:0]  cfg_step = 4'd1;
   logic [3:0]  prio_o;

   int n_cmp = 0, n_bad = 0, cyc = 0, exp_p = 0;
   int q[$];
   bit done = 0;

   always #10 clk = ~clk;

   lat_prio_regulator dut_i (
      .clk(clk), .rst_n(rst_n), .enable(enable),
      .req_valid(req_valid), .req_ready(req_ready),
      .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_last(rsp_last),
      .cfg_target(cfg_target), .cfg_step(cfg_step), .prio_o(prio_o)
   );

   task automatic check(input string tag);
      n_cmp++;
      if (int'(prio_o) != exp_p) begin
         n_bad++;
         $display("FAIL %s: prio actual %0d expected %0d (cycle %0d)", tag, prio_o, exp_p, cyc);
      end
   endtask

   // one clock: drive after falling edge, model at rising edge, sample mid-phase
   task automatic tick(input bit rqv, input bit rqr, input bit rsv, input bit rsr, input bit ls);
      int lat;
      @(negedge clk);
      req_valid = rqv; req_ready = rqr; rsp_valid = rsv; rsp_ready = rsr; rsp_last = ls;
      @(posedge clk);
      cyc++;
      if (!enable) begin
         q.delete();
         exp_p = 0;
      end else begin
         if (rsv && rsr && ls && q.size() > 0) begin
            lat = cyc - q.pop_front();
            if (lat > int'(cfg_target))      exp_p = (exp_p + int'(cfg_step) > 15) ? 15 : exp_p + int'(cfg_step);
            else if (lat < int'(cfg_target)) exp_p = (exp_p < int'(cfg_step)) ? 0 : exp_p - int'(cfg_step);
         end
         if (rqv && rqr) q.push_back(cyc);
      end
      #5;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) tick(0, 0, 0, 0, 0);
   endtask

   task automatic one_txn(input int lat, input string tag);
      tick(1, 1, 0, 0, 0);
      idle(lat - 1);
      tick(0, 0, 1, 1, 1);
      check(tag);
   endtask

   task automatic restart();
      @(negedge clk); enable = 1'b0;
      tick(0, 0, 0, 0, 0);
      check("R1 disable clears");
      @(negedge clk); enable = 1'b1;
   endtask

   initial begin
      #200;
      @(negedge clk); rst_n = 1'b1;
      #5;
      check("R1 reset");
      @(negedge clk); enable = 1'b1;
      idle(2);
      check("R1 after enable");

      // sweep: step 1..3, latency 1..8 around target 4
      for (int s = 1; s <= 3; s++) begin
         restart();
         cfg_step = 4'(s);
         for (int l = 1; l <= 8; l++)
            one_txn(l, (l > 4) ? "R4 R3 raise" : (l < 4) ? "R5 R3 lower" : "R6 equal");
         for (int l = 8; l >= 1; l--)
            one_txn(l, (l > 4) ? "R4 R3 raise" : (l < 4) ? "R5 R3 lower" : "R6 equal");
      end

      // saturation high
      restart();
      cfg_step = 4'd6; cfg_target = 16'd2;
      for (int i = 0; i < 5; i++) one_txn(5, "R4 saturate 15");
      cfg_step = 4'd15;
      one_txn(7, "R4 no wrap");
      // saturation low
      cfg_step = 4'd4;
      for (int i = 0; i < 6; i++) one_txn(1, "R5 saturate 0");
      cfg_step = 4'd15;
      one_txn(1, "R5 no wrap");

      // handshake qualification
      restart();
      cfg_step = 4'd2; cfg_target = 16'd3;
      tick(1, 0, 0, 0, 0);                 // valid without ready
      tick(0, 0, 1, 1, 1);
      check("R2 R8 unaccepted request");
      tick(1, 1, 0, 0, 0);
      idle(4);
      tick(0, 0, 1, 1, 0);                 // non-last beat
      check("R2 non-last beat");
      tick(0, 0, 1, 0, 1);                 // last without ready
      check("R2 no response handshake");
      tick(0, 0, 1, 1, 1);                 // latency 7
      check("R2 R4 completion");

      // empty queue completion, including same-edge request
      tick(0, 0, 1, 1, 1);
      check("R8 nothing outstanding");
      tick(1, 1, 1, 1, 1);
      check("R8 same-edge first request");
      idle(1);
      tick(0, 0, 1, 1, 1);                 // latency 2 on that request
      check("R8 R5 request still tracked");

      // overlapping streams, push and pop at same edge
      for (int r = 0; r < 3; r++) begin
         restart();
         cfg_step = 4'(r + 1); cfg_target = 16'(3 + 2 * r);
         for (int i = 0; i < 8; i++) tick(1, 1, 0, 0, 0);
         check("R7 fill to depth");
         for (int i = 0; i < 12; i++) begin
            tick((i % 2) == 0 && i < 8, 1, 1, 1, 1);
            check("R7 R9 overlap");
         end
         idle(2);
         check("R9 quiet");
      end

      // disable drops outstanding stamps
      restart();
      cfg_step = 4'd3; cfg_target = 16'd2;
      one_txn(6, "R4 before disable");
      tick(1, 1, 0, 0, 0);
      restart();
      tick(0, 0, 1, 1, 1);
      check("R1 R8 stale response ignored");

      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

endmodule